// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of general-purpose pins behind a 32-bit word-addressed register port. Software sets each pin's direction and stored output level. It can change either one as a whole word, or through companion registers that set or clear only the bits written as one. A per-pin pull-disable bit and a per-pin alternate-function bit complete the pad control. When an input pin has its pull enabled, the stored output bit chooses between pull-up and pull-down.

Pin inputs are resynchronised to the bank clock. A change between two consecutive synchronised samples counts as an edge. A rising-edge mask and a separate falling-edge mask decide which edges latch a pin's status bit. Software clears status bits by writing ones to a clear register. A single registered, active-high interrupt line reports that any status bit is pending.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the stored data, direction, alternate-function, rising mask, falling mask and status registers are all zero. The pull-disable register (offset 0x0C) reads all ones, and `irq`, `pin_oe` and `pull_en` are low.
- R2: A write to offset 0x04 sets the stored data bits written as 1, and a write to 0x08 clears them. All other bits keep their value. A write to 0x00 loads the whole stored data word.
- R3: A write to offset 0x14 sets the direction bits written as 1, and a write to 0x18 clears them. All other bits keep their value. A write to 0x10 loads the whole word, and reading 0x10 returns it. A direction bit of 1 means output.
- R4: For a pin whose alternate-function bit is 0, `pin_oe` equals its direction bit. `pin_out` equals its stored data bit while the direction bit is 1, and is 0 otherwise.
- R5: A read of offset 0x00 returns the pin levels after the input synchronizer, in bit positions 0..NPINS-1 with zeros above.
- R6: `pull_en` is 1 only for a pin whose direction bit is 0, whose pull-disable bit is 0 and whose alternate-function bit is 0. For such a pin, `pull_up` equals its stored data bit; otherwise `pull_up` is 0.
- R7: While a pin's alternate-function bit (offset 0x20) is 1, its `pin_oe`, `pin_out`, `pull_en` and `pull_up` are all 0.
- R8: A rising edge on a pin sets its status bit (offset 0x48) only when its rising-mask bit (offset 0x40) is 1. With both masks 0, edges leave the status unchanged.
- R9: A falling edge sets the status bit only when its falling-mask bit (offset 0x44) is 1. With both mask bits at 1, either edge sets it.
- R10: Writing 1 to a bit at offset 0x4C clears that status bit, and bits written as 0 are unchanged. Writes to the status offset 0x48 have no effect.
- R11: When an edge and a clear hit the same status bit in the same cycle, the status bit stays set.
- R12: `irq` is the OR of all status bits, registered, so it follows the status register one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` (combinational) |
| pin_in | input | NPINS | Pin levels from the pads (asynchronous) |
| pin_out | output | NPINS | Output level to the pads |
| pin_oe | output | NPINS | Output enable to the pads |
| pull_en | output | NPINS | Pull resistor enable to the pads |
| pull_up | output | NPINS | Pull direction: 1 up, 0 down |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the bank with NPINS = 8 and SYNC_STAGES = 2. The narrow width checks that register bits above the pin count read back as zero, for example when a mask is written with all ones. The fixed synchronizer depth lets the bench compute the exact cycle in which an edge reaches the status register. It uses that cycle to line a clear write up with an edge for the collision case, and to check that the interrupt line lags the status by one cycle.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants of the GPIO bank.
// Assumes a 7-bit byte address, 32-bit word-aligned registers.
package gpio_bank_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_DATA  = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_DSET  = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_DCLR  = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_PDIS  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 7'h10;
    localparam logic [ADDR_W-1:0] OFF_DIRS  = 7'h14;
    localparam logic [ADDR_W-1:0] OFF_DIRC  = 7'h18;
    localparam logic [ADDR_W-1:0] OFF_ALT   = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_RMSK  = 7'h40;
    localparam logic [ADDR_W-1:0] OFF_FMSK  = 7'h44;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h48;
    localparam logic [ADDR_W-1:0] OFF_ICLR  = 7'h4C;
endpackage

// File: rtl/gpio_bank_sync.sv
// Module: multi-stage input synchronizer, one chain per pin.
// Assumes pin inputs are asynchronous; STAGES >= 2; resets to 0.
module gpio_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
// Module: register file and read mux of the GPIO bank.
// Assumes writes take effect on the clock edge where bus_wr is high;
// reads are combinational; bits above NPINS read as zero.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pdis_q,
    output logic [NPINS-1:0]  alt_q,
    output logic [NPINS-1:0]  rmask_q,
    output logic [NPINS-1:0]  fmask_q,
    output logic [NPINS-1:0]  clr_vec
);
    function automatic logic [DATA_W-1:0] widen(input logic [NPINS-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    logic [NPINS-1:0] wbits;
    logic             hit_data, hit_dset, hit_dclr, hit_pdis;
    logic             hit_dir, hit_dirs, hit_dirc, hit_alt;
    logic             hit_rmsk, hit_fmsk, hit_iclr;
    logic [NPINS-1:0] data_d, dir_d;

    assign wbits = bus_wdata[NPINS-1:0];

    // Decode the write strobe per register.
    always_comb begin
        hit_data = bus_wr && (bus_addr == OFF_DATA);
        hit_dset = bus_wr && (bus_addr == OFF_DSET);
        hit_dclr = bus_wr && (bus_addr == OFF_DCLR);
        hit_pdis = bus_wr && (bus_addr == OFF_PDIS);
        hit_dir  = bus_wr && (bus_addr == OFF_DIR);
        hit_dirs = bus_wr && (bus_addr == OFF_DIRS);
        hit_dirc = bus_wr && (bus_addr == OFF_DIRC);
        hit_alt  = bus_wr && (bus_addr == OFF_ALT);
        hit_rmsk = bus_wr && (bus_addr == OFF_RMSK);
        hit_fmsk = bus_wr && (bus_addr == OFF_FMSK);
        hit_iclr = bus_wr && (bus_addr == OFF_ICLR);
    end

    // Next stored data: whole-word load, bitwise set or bitwise clear.
    always_comb begin
        data_d = data_q;
        if (hit_data)      data_d = wbits;
        else if (hit_dset) data_d = data_q | wbits;
        else if (hit_dclr) data_d = data_q & ~wbits;
    end

    // Next direction: whole-word load, bitwise set or bitwise clear.
    always_comb begin
        dir_d = dir_q;
        if (hit_dir)       dir_d = wbits;
        else if (hit_dirs) dir_d = dir_q | wbits;
        else if (hit_dirc) dir_d = dir_q & ~wbits;
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            pdis_q  <= '1;
            alt_q   <= '0;
            rmask_q <= '0;
            fmask_q <= '0;
        end else begin
            data_q <= data_d;
            dir_q  <= dir_d;
            if (hit_pdis) pdis_q  <= wbits;
            if (hit_alt)  alt_q   <= wbits;
            if (hit_rmsk) rmask_q <= wbits;
            if (hit_fmsk) fmask_q <= wbits;
        end
    end

    // Clear request vector for the status register.
    assign clr_vec = hit_iclr ? wbits : '0;

    // Read multiplexer.
    always_comb begin
        unique case (bus_addr)
            OFF_DATA: bus_rdata = widen(pin_lvl);
            OFF_PDIS: bus_rdata = widen(pdis_q);
            OFF_DIR:  bus_rdata = widen(dir_q);
            OFF_ALT:  bus_rdata = widen(alt_q);
            OFF_RMSK: bus_rdata = widen(rmask_q);
            OFF_FMSK: bus_rdata = widen(fmask_q);
            OFF_STAT: bus_rdata = widen(status);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_irq.sv
// Module: edge detector, sticky status register and interrupt line.
// Assumes synchronised inputs; a new edge wins over a same-cycle clear.
module gpio_bank_irq #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] rmask,
    input  logic [NPINS-1:0] fmask,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] edge_hit,
    output logic [NPINS-1:0] status_q,
    output logic             irq_q
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] rise, fall;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Qualify edges with their masks.
    always_comb begin
        rise     = lvl & ~prev_q;
        fall     = ~lvl & prev_q;
        edge_hit = (rise & rmask) | (fall & fmask);
    end

    // Sticky status: clear first, then new edges set.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | edge_hit;
    end

    // Registered combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_q;
    end
endmodule

// File: rtl/gpio_bank_pad.sv
// Module: pad control gating from direction, data, pulls and alternate select.
// Assumes purely combinational pad controls; alternate select overrides all.
module gpio_bank_pad #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] data,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] pdis,
    input  logic [NPINS-1:0] alt,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pull_en,
    output logic [NPINS-1:0] pull_up
);
    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // Per-pin drive and pull selection.
            always_comb begin
                pin_oe[i]  = dir[i] & ~alt[i];
                pin_out[i] = data[i] & dir[i] & ~alt[i];
                pull_en[i] = ~dir[i] & ~pdis[i] & ~alt[i];
                pull_up[i] = pull_en[i] & data[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
// Module: GPIO bank top: registers, synchronizer, edge interrupts, pad control.
// Assumes NPINS <= 32 and one clock domain for the register port.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pull_en,
    output logic [NPINS-1:0]  pull_up,
    output logic              irq
);
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] data_q, dir_q, pdis_q, alt_q, rmask_q, fmask_q;
    logic [NPINS-1:0] clr_vec, edge_hit, status_q;

    gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl)
    );

    gpio_bank_regs #(.NPINS(NPINS)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(lvl),
        .status(status_q), .data_q(data_q), .dir_q(dir_q), .pdis_q(pdis_q),
        .alt_q(alt_q), .rmask_q(rmask_q), .fmask_q(fmask_q), .clr_vec(clr_vec)
    );

    gpio_bank_irq #(.NPINS(NPINS)) irq_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rmask(rmask_q), .fmask(fmask_q),
        .clr(clr_vec), .edge_hit(edge_hit), .status_q(status_q), .irq_q(irq)
    );

    gpio_bank_pad #(.NPINS(NPINS)) pad_i (
        .data(data_q), .dir(dir_q), .pdis(pdis_q), .alt(alt_q),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: property checker for the GPIO bank, bound to gpio_bank.
// Assumes synchronous active-low reset; observes ports and bank state.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pull_en,
    input logic              irq,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  pdis_q,
    input logic [NPINS-1:0]  alt_q,
    input logic [NPINS-1:0]  edge_hit,
    input logic [NPINS-1:0]  status_q
);
    logic [NPINS-1:0] wb;
    assign wb = bus_wdata[NPINS-1:0];

    AST_RESET_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pdis_q == '1 && status_q == '0 && !irq)); // R1
    AST_DATA_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DSET) |=> ((data_q & $past(wb)) == $past(wb))); // R2
    AST_DIR_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DIRC) |=> ((dir_q & $past(wb)) == '0)); // R3
    AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_en & pin_oe) == '0)); // R6
    AST_ALT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe | pull_en) & alt_q) == '0)); // R7
    AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_hit)) == '0)); // R8
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ICLR) |=> ((status_q & $past(wb & ~edge_hit)) == '0)); // R10
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(edge_hit)) == $past(edge_hit))); // R11
    AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|status_q))); // R12
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq),
    .data_q(data_q), .dir_q(dir_q), .pdis_q(pdis_q), .alt_q(alt_q),
    .edge_hit(edge_hit), .status_q(status_q)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    import gpio_bank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    typedef struct packed {
        logic          wr;
        logic [6:0]    waddr;
        logic [31:0]   wdata;
        logic [NP-1:0] pins;
        logic [6:0]    raddr;
        logic [31:0]   exp_rd;
        logic [NP-1:0] exp_out;
        logic [NP-1:0] exp_oe;
        logic [7:0]    tag;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, OFF_DIRS, 32'h0000_00FF, 8'h00, OFF_DIR,  32'hFF, 8'h00, 8'hFF, 8'd3}, // R3
        '{1'b1, OFF_DSET, 32'h0000_000F, 8'h00, OFF_DIR,  32'hFF, 8'h0F, 8'hFF, 8'd2}, // R2
        '{1'b1, OFF_DSET, 32'h0000_0030, 8'h00, OFF_DIR,  32'hFF, 8'h3F, 8'hFF, 8'd2}, // R2
        '{1'b1, OFF_DCLR, 32'h0000_0005, 8'h00, OFF_DIR,  32'hFF, 8'h3A, 8'hFF, 8'd2}, // R2
        '{1'b1, OFF_DIRC, 32'h0000_00F0, 8'h00, OFF_DIR,  32'h0F, 8'h0A, 8'h0F, 8'd4}, // R3 R4
        '{1'b1, OFF_ALT,  32'h0000_0003, 8'h00, OFF_ALT,  32'h03, 8'h08, 8'h0C, 8'd7}, // R7
        '{1'b1, OFF_ALT,  32'h0000_0000, 8'hA5, OFF_DATA, 32'hA5, 8'h0A, 8'h0F, 8'd5}, // R5
        '{1'b1, OFF_DIR,  32'h0000_0000, 8'h5A, OFF_DATA, 32'h5A, 8'h00, 8'h00, 8'd5}, // R5
        '{1'b1, OFF_RMSK, 32'hFFFF_FFFF, 8'h5A, OFF_RMSK, 32'hFF, 8'h00, 8'h00, 8'd8}, // R8
        '{1'b1, OFF_RMSK, 32'h0000_0000, 8'h00, OFF_STAT, 32'h00, 8'h00, 8'h00, 8'd8}, // R8
        '{1'b1, OFF_STAT, 32'h0000_00FF, 8'h00, OFF_STAT, 32'h00, 8'h00, 8'h00, 8'd10}, // R10
        '{1'b0, OFF_DATA, 32'h0000_0000, 8'h00, OFF_PDIS, 32'hFF, 8'h00, 8'h00, 8'd1}  // R1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pull_en, pull_up;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NPINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .pull_up(pull_up), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rreg(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rreg(OFF_PDIS, rd); check("R1 pdis", rd, 32'hFF);
        rreg(OFF_DIR, rd);  check("R1 dir", rd, 32'h0);
        rreg(OFF_STAT, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 oe", {24'b0, pin_oe}, 32'h0);
        check("R1 pull_en", {24'b0, pull_en}, 32'h0);

        // Vector table
        foreach (VEC[k]) begin
            string tg;
            tg = $sformatf("R%0d", VEC[k].tag);
            @(negedge clk);
            pin_in = VEC[k].pins;
            if (VEC[k].wr) wreg(VEC[k].waddr, VEC[k].wdata);
            settle(3);
            rreg(VEC[k].raddr, rd);
            check({tg, " rd"}, rd, VEC[k].exp_rd);
            check({tg, " out"}, {24'b0, pin_out}, {24'b0, VEC[k].exp_out});
            check({tg, " oe"}, {24'b0, pin_oe}, {24'b0, VEC[k].exp_oe});
        end

        // R6 pulls: data=3A, dir=0, alt=0
        wreg(OFF_PDIS, 32'h0); settle(1);
        check("R6 pull_en", {24'b0, pull_en}, 32'hFF);
        check("R6 pull_up", {24'b0, pull_up}, 32'h3A);
        wreg(OFF_DIRS, 32'h01); settle(1);
        check("R6 pull_en output pin", {24'b0, pull_en}, 32'hFE);
        check("R4 oe pin0", {24'b0, pin_oe}, 32'h01);
        wreg(OFF_ALT, 32'h02); settle(1);
        check("R7 pull_en alt", {24'b0, pull_en}, 32'hFC);
        check("R7 pull_up alt", {24'b0, pull_up}, 32'h38);
        wreg(OFF_ALT, 32'h0); wreg(OFF_DIR, 32'h0); wreg(OFF_PDIS, 32'hFF);

        // R8 / R12: rising edge on pin0
        wreg(OFF_ICLR, 32'hFF);
        wreg(OFF_RMSK, 32'h01);
        @(negedge clk) pin_in[0] = 1'b1;
        for (int t = 0; t < 10; t++) begin
            rreg(OFF_STAT, rd);
            if (rd != 0) break;
        end
        check("R8 rise status", rd, 32'h01);
        check("R12 irq not yet", {31'b0, irq}, 32'h0);
        settle(1); #1;
        check("R12 irq next cycle", {31'b0, irq}, 32'h1);
        wreg(OFF_ICLR, 32'hFE); settle(2);
        rreg(OFF_STAT, rd); check("R10 zero bits keep", rd, 32'h01);
        wreg(OFF_ICLR, 32'h01); settle(2);
        rreg(OFF_STAT, rd); check("R10 cleared", rd, 32'h0);
        check("R12 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk) pin_in[0] = 1'b0; settle(5);
        rreg(OFF_STAT, rd); check("R8 fall ignored", rd, 32'h0);

        // R9: both edges on pin1, falling only on pin3
        wreg(OFF_RMSK, 32'h02); wreg(OFF_FMSK, 32'h0A);
        @(negedge clk) pin_in[1] = 1'b1; settle(5);
        rreg(OFF_STAT, rd); check("R9 both rise", rd, 32'h02);
        wreg(OFF_ICLR, 32'h02);
        @(negedge clk) pin_in[1] = 1'b0; settle(5);
        rreg(OFF_STAT, rd); check("R9 both fall", rd, 32'h02);
        wreg(OFF_ICLR, 32'h02);
        @(negedge clk) pin_in[3] = 1'b1; settle(5);
        rreg(OFF_STAT, rd); check("R9 rise w/o mask", rd, 32'h0);
        @(negedge clk) pin_in[3] = 1'b0; settle(5);
        rreg(OFF_STAT, rd); check("R9 fall only", rd, 32'h08);
        wreg(OFF_ICLR, 32'hFF);

        // R11: edge and clear in the same cycle on pin2
        wreg(OFF_RMSK, 32'h04); wreg(OFF_FMSK, 32'h04);
        @(negedge clk) pin_in[2] = 1'b1; settle(5);
        rreg(OFF_STAT, rd); check("R11 setup", rd, 32'h04);
        @(negedge clk) pin_in[2] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFF_ICLR; bus_wdata = 32'h04;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rreg(OFF_STAT, rd); check("R11 edge wins", rd, 32'h04);
        wreg(OFF_ICLR, 32'h04); settle(1);
        rreg(OFF_STAT, rd); check("R11 later clear", rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule